// File: doc/BRIEF.md
# Configurable Three-Input Logic Cell

This block is one fine-grained programmable cell. A static configuration word, written through a small port on the system clock, selects what the cell is. In combinational mode it evaluates a truth table over its three logic inputs, with each input optionally inverted first. In the four sequential modes the same three inputs take new roles. The first is data, the second is the clock or latch enable, and the third is an asynchronous clear or set. The cell then behaves as a transparent latch or as a rising-edge flip-flop.

The configuration word is laid out as follows. Bits [7:0] hold the truth table. The table is indexed by {in3,in2,in1}, taken after inversion, with in1 as the least significant bit. Bits [10:8] are the inversion enables for in1, in2 and in3 in that order. Bits [13:11] are the mode code: 0 combinational, 1 latch with clear, 2 latch with set, 3 flip-flop with clear, 4 flip-flop with set. Codes 5 to 7 are illegal.

A write that asks for the three-input parity function in combinational mode is refused, because the cell cannot realise it. A write with an illegal mode code is also refused. A refused write leaves the old configuration in place and raises a sticky error flag.

Top module: `lcell_top`

## Requirements
- R1: In combinational mode (code 0), `cell_out` equals bit {in3,in2,in1} of the truth table (bits [7:0]), with the index taken after inversion.
- R2: Inversion bit 8+i (i = 0, 1, 2) inverts input `cell_in[i]` before any use, in every mode. This includes the data, the clock/enable and the clear/set inputs.
- R3: A write with mode code 0 and truth table 8'h96 or 8'h69 is refused, and the previous configuration stays in force. The same tables are accepted when the mode is sequential.
- R4: A write with mode code 5, 6 or 7 is refused, and the previous configuration stays in force.
- R5: `cfg_err` goes to 1 on a refused write. It stays at 1 while no write occurs, and it returns to 0 on the next accepted write.
- R6: The configuration and `cfg_err` change only on a rising `clk` edge at which `cfg_en` is 1. An accepted word is in force from that edge onward.
- R7: In latch modes (codes 1 and 2), the output follows the effective in1 while the effective in2 is 1. It holds its value while the effective in2 is 0.
- R8: In latch modes, an effective in3 of 1 forces the output to 0 (code 1) or to 1 (code 2), overriding the enable.
- R9: In flip-flop modes (codes 3 and 4), the effective in1 is captured on a rising edge of the effective in2. At all other times the output holds.
- R10: In flip-flop modes, an effective in3 of 1 forces the output to 0 (code 3) or to 1 (code 4) at once, and this takes priority over clock edges.
- R11: While `rst_n` is 0, and after it is released, the configuration is all zeros (combinational, table 0, no inversion), `cell_out` is 0 and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the configuration port |
| rst_n | input | 1 | Asynchronous active-low reset of configuration and storage |
| cfg_en | input | 1 | Configuration write strobe |
| cfg_data | input | 14 | Configuration word (table, inversion, mode) |
| cell_in | input | 3 | Logic inputs in1 (bit 0), in2 (bit 1), in3 (bit 2) |
| cell_out | output | 1 | Cell output |
| cfg_err | output | 1 | Sticky flag for a refused configuration write |

## Verification
The bench builds the cell at its default of three inputs. This is the width at which the data, clock and clear/set roles all exist. At this width the two parity tables are exactly 8'h96 and 8'h69, and all five legal mode codes and the three illegal codes can be written. A table of combinational vectors covers several functions under different inversion masks. Directed sequences then drive in2 as a clock or an enable, in plain and inverted polarity, and hold in3 active across clock edges to show that the asynchronous override wins.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_COMB    = 3'd0,
        MODE_LAT_CLR = 3'd1,
        MODE_LAT_SET = 3'd2,
        MODE_FF_CLR  = 3'd3,
        MODE_FF_SET  = 3'd4
    } cell_mode_e;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return m <= 3'd4;
    endfunction

    function automatic logic mode_is_flop(input cell_mode_e m);
        return (m == MODE_FF_CLR) || (m == MODE_FF_SET);
    endfunction

    function automatic logic mode_is_latch(input cell_mode_e m);
        return (m == MODE_LAT_CLR) || (m == MODE_LAT_SET);
    endfunction

endpackage

// File: rtl/lcell_cfg.sv
module lcell_cfg
    import lcell_pkg::*;
#(
    parameter  int NUM_IN = 3,
    localparam int TBL_W  = 1 << NUM_IN,
    localparam int CFG_W  = TBL_W + NUM_IN + MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_word,
    output logic [CFG_W-1:0] word_q,
    output logic             err_q
);

    typedef struct packed {
        logic [CFG_W-1:0] word;
        logic             err;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    // Odd-parity truth table; its complement is the even-parity table.
    logic [TBL_W-1:0] odd_tbl;

    for (genvar g = 0; g < TBL_W; g++) begin : g_par
        localparam logic [NUM_IN-1:0] IDX = NUM_IN'(g);
        assign odd_tbl[g] = ^IDX;
    end

    logic [MODE_W-1:0] wr_mode;
    logic [TBL_W-1:0]  wr_tbl;
    logic              is_parity;
    logic              refuse;

    always_comb begin
        wr_mode   = wr_word[TBL_W+NUM_IN +: MODE_W];
        wr_tbl    = wr_word[TBL_W-1:0];
        is_parity = (wr_tbl == odd_tbl) || (wr_tbl == ~odd_tbl);
        refuse    = !mode_legal(wr_mode) ||
                    ((wr_mode == MODE_COMB) && is_parity);

        state_d = state_q;
        if (wr_en) begin
            if (refuse) begin
                state_d.err = 1'b1;
            end else begin
                state_d.word = wr_word;
                state_d.err  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_q = state_q.word;
    assign err_q  = state_q.err;

endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
    parameter  int NUM_IN = 3,
    localparam int TBL_W  = 1 << NUM_IN
) (
    input  logic [TBL_W-1:0]  tbl,
    input  logic [NUM_IN-1:0] inv,
    input  logic [NUM_IN-1:0] cell_in,
    output logic [NUM_IN-1:0] eff_in,
    output logic              lut_out
);

    for (genvar g = 0; g < NUM_IN; g++) begin : g_inv
        assign eff_in[g] = cell_in[g] ^ inv[g];
    end

    assign lut_out = tbl[eff_in];

endmodule

// File: rtl/lcell_store.sv
module lcell_store
    import lcell_pkg::*;
(
    input  logic       rst_n,
    input  cell_mode_e mode,
    input  logic       d,
    input  logic       g,
    input  logic       r,
    output logic       q
);

    logic lat_clr, lat_set, lat_q;
    logic ff_clr, ff_set, ff_q;

    // Latch: clear/set override, transparent while g is high.
    assign lat_clr = ((mode == MODE_LAT_CLR) && r) || !rst_n;
    assign lat_set = (mode == MODE_LAT_SET) && r && rst_n;

    always_latch begin
        if (lat_clr) begin
            lat_q <= 1'b0;
        end else if (lat_set) begin
            lat_q <= 1'b1;
        end else if (g) begin
            lat_q <= d;
        end
    end

    // Flip-flop: rising edge of g, asynchronous clear/set first.
    assign ff_clr = ((mode == MODE_FF_CLR) && r) || !rst_n;
    assign ff_set = (mode == MODE_FF_SET) && r && rst_n;

    always_ff @(posedge g or posedge ff_clr or posedge ff_set) begin
        if (ff_clr) begin
            ff_q <= 1'b0;
        end else if (ff_set) begin
            ff_q <= 1'b1;
        end else begin
            ff_q <= d;
        end
    end

    assign q = mode_is_flop(mode) ? ff_q : lat_q;

endmodule

// File: rtl/lcell_top.sv
module lcell_top
    import lcell_pkg::*;
#(
    parameter  int NUM_IN = 3,
    localparam int TBL_W  = 1 << NUM_IN,
    localparam int CFG_W  = TBL_W + NUM_IN + MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic [NUM_IN-1:0] cell_in,
    output logic              cell_out,
    output logic              cfg_err
);

    logic [CFG_W-1:0]  cfg_word;
    logic [TBL_W-1:0]  cfg_tbl;
    logic [NUM_IN-1:0] cfg_inv;
    cell_mode_e        cfg_mode;
    logic [NUM_IN-1:0] eff_in;
    logic              lut_out;
    logic              st_q;

    lcell_cfg #(.NUM_IN(NUM_IN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_en),
        .wr_word (cfg_data),
        .word_q  (cfg_word),
        .err_q   (cfg_err)
    );

    assign cfg_tbl  = cfg_word[TBL_W-1:0];
    assign cfg_inv  = cfg_word[TBL_W +: NUM_IN];
    assign cfg_mode = cell_mode_e'(cfg_word[TBL_W+NUM_IN +: MODE_W]);

    lcell_lut #(.NUM_IN(NUM_IN)) u_lut (
        .tbl     (cfg_tbl),
        .inv     (cfg_inv),
        .cell_in (cell_in),
        .eff_in  (eff_in),
        .lut_out (lut_out)
    );

    lcell_store u_store (
        .rst_n (rst_n),
        .mode  (cfg_mode),
        .d     (eff_in[0]),
        .g     (eff_in[1]),
        .r     (eff_in[2]),
        .q     (st_q)
    );

    assign cell_out = (cfg_mode == MODE_COMB) ? lut_out : st_q;

endmodule

// File: rtl/lcell_top_chk.sv
module lcell_top_chk
    import lcell_pkg::*;
#(
    parameter  int NUM_IN = 3,
    localparam int TBL_W  = 1 << NUM_IN,
    localparam int CFG_W  = TBL_W + NUM_IN + MODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic [CFG_W-1:0]  cfg_data,
    input logic [NUM_IN-1:0] cell_in,
    input logic              cell_out,
    input logic              cfg_err,
    input logic [CFG_W-1:0]  cfg_word
);

    logic [TBL_W-1:0]  par_tbl;
    logic [MODE_W-1:0] req_mode, cur_mode;
    logic              req_bad;
    logic              e_d, e_g, e_r;

    always_comb begin
        for (int i = 0; i < TBL_W; i++) begin
            par_tbl[i] = ($countones(i) % 2) == 1;
        end
        req_mode = cfg_data[TBL_W+NUM_IN +: MODE_W];
        req_bad  = (req_mode > 3'd4) ||
                   ((req_mode == 3'd0) &&
                    ((cfg_data[TBL_W-1:0] == par_tbl) ||
                     (cfg_data[TBL_W-1:0] == ~par_tbl)));
        cur_mode = cfg_word[TBL_W+NUM_IN +: MODE_W];
        e_d      = cell_in[0] ^ cfg_word[TBL_W];
        e_g      = cell_in[1] ^ cfg_word[TBL_W+1];
        e_r      = cell_in[2] ^ cfg_word[TBL_W+2];
    end

    // R3, R4: refused writes keep the configuration
    a_r3_parity_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && req_bad && req_mode == 3'd0) |=> $stable(cfg_word));
    a_r4_bad_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && req_mode > 3'd4) |=> $stable(cfg_word));

    // R5: sticky error
    a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && req_bad) |=> cfg_err);
    a_r5_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !req_bad) |=> !cfg_err);
    a_r5_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_err));

    // R6: write timing
    a_r6_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !req_bad) |=> (cfg_word == $past(cfg_data)));
    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_word));

    // R7: transparent latch
    a_r7_latch_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == 3'd1 || cur_mode == 3'd2) && e_g && !e_r)
        |-> (cell_out == e_d));

    // R8, R10: asynchronous override
    a_r8_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == 3'd1 || cur_mode == 3'd3) && e_r) |-> !cell_out);
    a_r8_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == 3'd2 || cur_mode == 3'd4) && e_r) |-> cell_out);

    // R11: state right after reset release
    a_r11_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cell_out && !cfg_err && cfg_word == '0));

endmodule

bind lcell_top lcell_top_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_data (cfg_data),
    .cell_in  (cell_in),
    .cell_out (cell_out),
    .cfg_err  (cfg_err),
    .cfg_word (cfg_word)
);

// File: tb/lcell_top_test.sv
module lcell_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_IN     = 3;
    localparam int CFG_W      = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_en = 1'b0;
    logic [CFG_W-1:0]  cfg_data = '0;
    logic [NUM_IN-1:0] cell_in = '0;
    logic              cell_out;
    logic              cfg_err;

    int checks = 0;
    int fails  = 0;

    lcell_top #(.NUM_IN(NUM_IN)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_data (cfg_data),
        .cell_in  (cell_in),
        .cell_out (cell_out),
        .cfg_err  (cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [CFG_W-1:0] mk(input logic [2:0] mode,
                                             input logic [2:0] inv,
                                             input logic [7:0] tbl);
        return {mode, inv, tbl};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [CFG_W-1:0] w);
        @(negedge clk);
        cfg_en   = 1'b1;
        cfg_data = w;
        @(negedge clk);
        cfg_en   = 1'b0;
    endtask

    task automatic drive(input logic [2:0] v);
        cell_in = v;
        #1;
    endtask

    // {mode, inv, table, {in3,in2,in1}, expected}
    localparam logic [17:0] VECS [12] = '{
        {3'd0, 3'b000, 8'hE8, 3'b011, 1'b1},
        {3'd0, 3'b000, 8'hE8, 3'b001, 1'b0},
        {3'd0, 3'b000, 8'hE8, 3'b110, 1'b1},
        {3'd0, 3'b000, 8'h80, 3'b111, 1'b1},
        {3'd0, 3'b000, 8'h80, 3'b110, 1'b0},
        {3'd0, 3'b001, 8'h80, 3'b110, 1'b1},
        {3'd0, 3'b111, 8'h80, 3'b000, 1'b1},
        {3'd0, 3'b000, 8'hFE, 3'b000, 1'b0},
        {3'd0, 3'b100, 8'hFE, 3'b000, 1'b1},
        {3'd0, 3'b000, 8'h01, 3'b000, 1'b1},
        {3'd0, 3'b000, 8'hAA, 3'b101, 1'b1},
        {3'd0, 3'b001, 8'hAA, 3'b101, 1'b0}
    };

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R11: reset state
        #(CLK_PERIOD * 2 + 1);
        chk("R11 out in reset", cell_out, 1'b0);
        chk("R11 err in reset", cfg_err, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(3'b111);
        chk("R11 table zero after reset", cell_out, 1'b0);

        // R6: no write without strobe, effect on next edge
        @(negedge clk);
        cfg_data = mk(3'd0, 3'b000, 8'h80);
        @(negedge clk);
        #1;
        chk("R6 ignored without cfg_en", cell_out, 1'b0);
        @(negedge clk);
        cfg_en = 1'b1;
        #1;
        chk("R6 not before edge", cell_out, 1'b0);
        @(posedge clk);
        #1;
        chk("R6 in force after edge", cell_out, 1'b1);
        @(negedge clk);
        cfg_en = 1'b0;

        // R1, R2: vector table
        for (int k = 0; k < 12; k++) begin
            wr(VECS[k][17:4]);
            drive(VECS[k][3:1]);
            chk($sformatf("R1/R2 vector %0d", k), cell_out, VECS[k][0]);
        end

        // R3, R5: parity refused, sticky error
        wr(mk(3'd0, 3'b000, 8'h80));
        drive(3'b001);
        wr(mk(3'd0, 3'b000, 8'h96));
        chk("R3 odd parity err", cfg_err, 1'b1);
        chk("R3 odd parity config kept", cell_out, 1'b0);
        wr(mk(3'd0, 3'b000, 8'h69));
        chk("R3 even parity err", cfg_err, 1'b1);
        chk("R3 even parity config kept", cell_out, 1'b0);
        repeat (3) @(negedge clk);
        chk("R5 err sticky while idle", cfg_err, 1'b1);
        wr(mk(3'd3, 3'b000, 8'h96));
        chk("R3 parity table accepted in flop mode", cfg_err, 1'b0);

        // R4: illegal mode codes
        wr(mk(3'd0, 3'b000, 8'h80));
        wr(mk(3'd5, 3'b000, 8'hFE));
        chk("R4 mode 5 err", cfg_err, 1'b1);
        drive(3'b001);
        chk("R4 mode 5 config kept", cell_out, 1'b0);
        wr(mk(3'd7, 3'b000, 8'hFE));
        chk("R4 mode 7 err", cfg_err, 1'b1);
        wr(mk(3'd0, 3'b000, 8'hFE));
        chk("R5 err cleared by accepted write", cfg_err, 1'b0);
        chk("R5 accepted write in force", cell_out, 1'b1);

        // R7, R8: latch with clear
        drive(3'b000);
        wr(mk(3'd1, 3'b000, 8'h00));
        drive(3'b011);
        chk("R7 latch follows 1", cell_out, 1'b1);
        drive(3'b010);
        chk("R7 latch follows 0", cell_out, 1'b0);
        drive(3'b011);
        drive(3'b001);
        chk("R7 latch holds on close", cell_out, 1'b1);
        drive(3'b000);
        chk("R7 latch holds while closed", cell_out, 1'b1);
        drive(3'b111);
        chk("R8 clear over enable", cell_out, 1'b0);
        drive(3'b001);
        chk("R8 clear released, holds 0", cell_out, 1'b0);

        // R8: latch with set, plain and inverted set input
        drive(3'b000);
        wr(mk(3'd2, 3'b000, 8'h00));
        drive(3'b100);
        chk("R8 latch set", cell_out, 1'b1);
        drive(3'b000);
        chk("R8 set released, holds 1", cell_out, 1'b1);
        drive(3'b010);
        chk("R7 set-latch follows 0", cell_out, 1'b0);
        drive(3'b000);
        wr(mk(3'd2, 3'b100, 8'h00));
        chk("R2 inverted set input forces 1", cell_out, 1'b1);

        // R9: flip-flop with clear
        wr(mk(3'd3, 3'b000, 8'h00));
        drive(3'b001);
        drive(3'b011);
        chk("R9 capture 1 on rise", cell_out, 1'b1);
        drive(3'b010);
        chk("R9 no capture while high", cell_out, 1'b1);
        drive(3'b000);
        chk("R9 no capture on fall", cell_out, 1'b1);
        drive(3'b010);
        chk("R9 capture 0 on rise", cell_out, 1'b0);
        wr(mk(3'd3, 3'b010, 8'h00));
        drive(3'b011);
        chk("R9 inverted clock, no capture", cell_out, 1'b0);
        drive(3'b001);
        chk("R2 inverted clock captures on fall of in2", cell_out, 1'b1);

        // R10: clear/set over clock
        drive(3'b101);
        chk("R10 async clear", cell_out, 1'b0);
        drive(3'b111);
        drive(3'b101);
        chk("R10 clear beats edge", cell_out, 1'b0);
        drive(3'b001);
        chk("R10 release, no edge", cell_out, 1'b0);
        drive(3'b000);
        wr(mk(3'd4, 3'b000, 8'h00));
        drive(3'b100);
        chk("R10 async set", cell_out, 1'b1);
        drive(3'b110);
        chk("R10 set beats edge", cell_out, 1'b1);
        drive(3'b010);
        chk("R10 set released, holds 1", cell_out, 1'b1);
        drive(3'b000);
        drive(3'b010);
        chk("R9 set-flop captures 0", cell_out, 1'b0);

        // R11: reset in mid operation
        wr(mk(3'd0, 3'b000, 8'hFF));
        wr(mk(3'd6, 3'b000, 8'h00));
        chk("R11 precondition err", cfg_err, 1'b1);
        rst_n = 1'b0;
        #1;
        chk("R11 err cleared by reset", cfg_err, 1'b0);
        chk("R11 out cleared by reset", cell_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(3'b101);
        chk("R11 comb zero table after reset", cell_out, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule